// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Unit

This block is the interrupt front end of a small 8-bit processor core. It watches five request inputs: a non-maskable line, three maskable restart lines (called high, middle and low here) and one general request line. It keeps a global enable flag that the core sets and clears with single-cycle strobes. It keeps a three-bit line mask that the core loads with a mask-write strobe and reads back as a status byte. Each cycle it picks the highest-priority live request and presents it as a request flag. For the four internal sources it also presents a 16-bit vector address and a vector-valid bit.

The core answers a presented request with a one-cycle acknowledge. An acknowledge clears the global enable flag. When the acknowledged source is the edge-latched high line, it also clears that latch. When it is the non-maskable line, it disarms that line until the input has gone low and high again. For the general request line the block raises the request flag only. The device on that line supplies its own vector, so the vector-valid bit stays low.

All state and every output is registered on the same clock edge that samples the inputs. An input change that is driven before an edge shows at the outputs right after that edge.

Top module: `irq_front`

## Requirements
- R1: Priority from highest to lowest is non-maskable line, high line, middle line, low line, general line. When several sources are live, only the highest one is presented.
- R2: The vector addresses are 0024h for the non-maskable line, 003Ch for the high line, 0034h for the middle line and 002Ch for the low line. When one of these is presented, `irq_vec_ok` is 1. When the general line is presented, `irq_req` is 1 and `irq_vec_ok` is 0.
- R3: The non-maskable line ignores the mask and the enable flag. It is presented while `trap_in` is high and has stayed high since a rising edge.
- R4: After the non-maskable line is acknowledged, it is not presented again until `trap_in` has been low and then high.
- R5: Every source except the non-maskable line needs the enable flag set. `ei_stb` sets the flag and `di_stb` clears it.
- R6: `ack` while `irq_req` is 1 clears the enable flag, with priority over `ei_stb`. `ack` while `irq_req` is 0 has no effect.
- R7: A mask write with `mask_wdata[3]`=1 loads `mask_wdata[2:0]` into the masks for the high, middle and low lines (bits 2, 1, 0). A mask bit of 0 enables its line and 1 masks it. With bit 3 at 0 the masks are kept.
- R8: A rising edge on `ln_hi_in` sets a pending latch that stays set after the input falls. The latch clears when the high line is acknowledged or when a mask write has `mask_wdata[4]`=1. A new edge in the same cycle wins over the clear.
- R9: The middle, low and general lines are level-sensitive. If one drops before it is acknowledged, it is no longer presented.
- R10: `mask_rdata` returns the masks in bits 2:0, the enable flag in bit 3, and the pending state of the low, middle and high lines in bits 4, 5 and 6. Bit 7 is 0.
- R11: Synchronous reset clears the enable flag, masks all three lines and clears `irq_req` and `irq_vec_ok`. `mask_rdata` then reads 07h.
- R12: Outputs reflect the inputs and strobes sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable request |
| ln_hi_in | input | 1 | Edge-triggered maskable line (highest of the three) |
| ln_mid_in | input | 1 | Level-sensitive maskable line |
| ln_lo_in | input | 1 | Level-sensitive maskable line (lowest of the three) |
| gen_req_in | input | 1 | General request without an internal vector |
| ei_stb | input | 1 | Set the enable flag |
| di_stb | input | 1 | Clear the enable flag |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | DW | Mask write data |
| ack | input | 1 | Acknowledge of the presented request |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector address of the presented source |
| irq_vec_ok | output | 1 | The vector address is valid |
| mask_rdata | output | DW | Status and mask readback |

## Verification
A wrong enable flag or a wrong mask bit shows in `mask_rdata` on the next edge. A stuck edge latch on the high line shows as a 003Ch request that never drops, or as a bit 6 in the readback that never clears. A non-maskable line that fails to disarm shows as 0024h presented again right after its acknowledge. The bench keeps a cycle-accurate reference from the requirements and compares the request, the vector, the valid bit and the readback after every edge, so any divergence shows within one cycle.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  localparam int NSRC      = 5;
  localparam int IDX_TRAP  = 0;
  localparam int IDX_HI    = 1;
  localparam int IDX_MID   = 2;
  localparam int IDX_LO    = 3;
  localparam int IDX_GEN   = 4;
  localparam int NMASK     = 3;
  localparam int WB_SETEN  = 3;
  localparam int WB_HICLR  = 4;
  localparam int RB_EN     = 3;
  localparam int RB_PLO    = 4;
  localparam int RB_PMID   = 5;
  localparam int RB_PHI    = 6;
endpackage

// File: rtl/edge_latch.sv
module edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  input  logic clr,
  output logic pend_n
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise   = lvl_in & ~prev_q;
  assign pend_n = (pend_q & ~clr) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      pend_q <= pend_n;
    end
  end

  // R8: a captured edge is held
  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (lvl_in && !prev_q) |=> pend_q);
  // R8: without a clear the latch stays set
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr) |=> pend_q);
endmodule

// File: rtl/trap_arm.sv
module trap_arm (
  input  logic clk,
  input  logic rst,
  input  logic trap_in,
  input  logic ack_trap,
  output logic armed_n
);
  logic prev_q;
  logic armed_q;

  assign armed_n = trap_in & ((trap_in & ~prev_q) | (armed_q & ~ack_trap));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= trap_in;
      armed_q <= armed_n;
    end
  end

  // R4: an acknowledge disarms the line
  assert_disarm_R4: assert property (@(posedge clk) disable iff (rst)
    ack_trap |=> !armed_q);
  // R3: a low input drops recognition
  assert_level_R3: assert property (@(posedge clk) disable iff (rst)
    !trap_in |=> !armed_q);
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ei,
  input  logic          di,
  input  logic          ack_any,
  input  logic          wr,
  input  logic          set_en,
  input  logic [MW-1:0] wmask,
  output logic [MW-1:0] mask_n,
  output logic          en_n
);
  logic [MW-1:0] mask_q;
  logic          en_q;

  always_comb begin
    mask_n = (wr && set_en) ? wmask : mask_q;
    if (ack_any)   en_n = 1'b0;
    else if (di)   en_n = 1'b0;
    else if (ei)   en_n = 1'b1;
    else           en_n = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= {MW{1'b1}};
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_n;
      en_q   <= en_n;
    end
  end

  // R6: an acknowledge leaves the flag clear
  assert_ack_disables_R6: assert property (@(posedge clk) disable iff (rst)
    ack_any |=> !en_q);
  // R7: masks only change on an enabled write
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr && set_en) |=> $stable(mask_q));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 5,
  parameter int VW = 16,
  parameter logic [N-1:0][VW-1:0] TAB  = '0,
  parameter logic [N-1:0]         HASV = '0
) (
  input  logic [N-1:0]  cand,
  output logic [N-1:0]  grant,
  output logic [VW-1:0] vec,
  output logic          vok
);
  logic [N-1:0][VW-1:0] part;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_part
      assign part[g] = (grant[g] && HASV[g]) ? TAB[g] : '0;
    end
  endgenerate

  always_comb begin
    vec = '0;
    for (int i = 0; i < N; i++) vec = vec | part[i];
  end

  assign vok = |(grant & HASV);
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_front_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter int               DW       = 8,
  parameter logic [VEC_W-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_HI   = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_MID  = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LO   = 16'h002C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_in,
  input  logic             ln_hi_in,
  input  logic             ln_mid_in,
  input  logic             ln_lo_in,
  input  logic             gen_req_in,
  input  logic             ei_stb,
  input  logic             di_stb,
  input  logic             mask_wr,
  input  logic [DW-1:0]    mask_wdata,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_vec_ok,
  output logic [DW-1:0]    mask_rdata
);
  localparam logic [NSRC-1:0][VEC_W-1:0] VTAB =
    {{VEC_W{1'b0}}, VEC_LO, VEC_MID, VEC_HI, VEC_TRAP};
  localparam logic [NSRC-1:0] HASV = NSRC'(5'b01111);
  localparam logic [DW-1:0]   RD_RST = DW'({NMASK{1'b1}});

  logic [NSRC-1:0]  src_q;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic             vok_q;
  logic [DW-1:0]    rd_q;

  logic             ack_ok;
  logic [NSRC-1:0]  ack_src;
  logic             armed_n;
  logic             hi_pend_n;
  logic             hi_clr;
  logic [NMASK-1:0] mask_n;
  logic             en_n;
  logic [NSRC-1:0]  cand;
  logic [NSRC-1:0]  grant;
  logic [VEC_W-1:0] vec_n;
  logic             vok_n;
  logic [DW-1:0]    rd_n;
  logic             unused_wbits;

  assign unused_wbits = ^mask_wdata[DW-1:WB_HICLR+1];

  assign ack_ok  = ack & req_q;
  assign ack_src = src_q & {NSRC{ack_ok}};
  assign hi_clr  = ack_src[IDX_HI] | (mask_wr & mask_wdata[WB_HICLR]);

  trap_arm u_trap (
    .clk      (clk),
    .rst      (rst),
    .trap_in  (trap_in),
    .ack_trap (ack_src[IDX_TRAP]),
    .armed_n  (armed_n)
  );

  edge_latch u_hi (
    .clk    (clk),
    .rst    (rst),
    .lvl_in (ln_hi_in),
    .clr    (hi_clr),
    .pend_n (hi_pend_n)
  );

  gate_ctrl #(.MW(NMASK)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .ei      (ei_stb),
    .di      (di_stb),
    .ack_any (ack_ok),
    .wr      (mask_wr),
    .set_en  (mask_wdata[WB_SETEN]),
    .wmask   (mask_wdata[NMASK-1:0]),
    .mask_n  (mask_n),
    .en_n    (en_n)
  );

  always_comb begin
    cand           = '0;
    cand[IDX_TRAP] = armed_n;
    cand[IDX_HI]   = en_n & hi_pend_n & ~mask_n[2];
    cand[IDX_MID]  = en_n & ln_mid_in & ~mask_n[1];
    cand[IDX_LO]   = en_n & ln_lo_in  & ~mask_n[0];
    cand[IDX_GEN]  = en_n & gen_req_in;
  end

  prio_pick #(.N(NSRC), .VW(VEC_W), .TAB(VTAB), .HASV(HASV)) u_pick (
    .cand  (cand),
    .grant (grant),
    .vec   (vec_n),
    .vok   (vok_n)
  );

  always_comb begin
    rd_n              = '0;
    rd_n[NMASK-1:0]   = mask_n;
    rd_n[RB_EN]       = en_n;
    rd_n[RB_PLO]      = ln_lo_in;
    rd_n[RB_PMID]     = ln_mid_in;
    rd_n[RB_PHI]      = hi_pend_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      req_q <= 1'b0;
      vec_q <= '0;
      vok_q <= 1'b0;
      rd_q  <= RD_RST;
    end else begin
      src_q <= grant;
      req_q <= |grant;
      vec_q <= vec_n;
      vok_q <= vok_n;
      rd_q  <= rd_n;
    end
  end

  assign irq_req    = req_q;
  assign irq_vec    = vec_q;
  assign irq_vec_ok = vok_q;
  assign mask_rdata = rd_q;

  // R1: at most one source presented
  assert_single_src_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_q));
  // R2: a valid vector implies a request
  assert_vec_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    irq_vec_ok |-> irq_req);
  // R4: the non-maskable line is not presented twice in a row across an acknowledge
  assert_no_retrap_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req && irq_vec_ok && irq_vec == VEC_TRAP) |=> !(irq_vec_ok && irq_vec == VEC_TRAP));
  // R6: after an accepted acknowledge the readback shows the flag clear
  assert_ack_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> !mask_rdata[RB_EN]);
endmodule

// File: tb/sim_irq_front.sv
`timescale 1ns/1ps
module sim_irq_front;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, trap_in, ln_hi_in, ln_mid_in, ln_lo_in, gen_req_in;
  logic ei_stb, di_stb, mask_wr, ack;
  logic [7:0]  mask_wdata;
  logic        irq_req, irq_vec_ok;
  logic [15:0] irq_vec;
  logic [7:0]  mask_rdata;

  irq_front u0 (
    .clk(clk), .rst(rst), .trap_in(trap_in), .ln_hi_in(ln_hi_in),
    .ln_mid_in(ln_mid_in), .ln_lo_in(ln_lo_in), .gen_req_in(gen_req_in),
    .ei_stb(ei_stb), .di_stb(di_stb), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ack(ack), .irq_req(irq_req), .irq_vec(irq_vec), .irq_vec_ok(irq_vec_ok),
    .mask_rdata(mask_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state, from the requirements
  bit       m_pt, m_armed, m_p75, m_lat, m_en, m_req, m_vok;
  bit [2:0] m_mask;
  int       m_src;
  bit [15:0] m_vec;
  bit [7:0]  m_rd;

  function automatic bit [15:0] vec_of(int s);
    case (s)
      0: return 16'h0024;
      1: return 16'h003C;
      2: return 16'h0034;
      3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    bit ackv, rise_t, rise75, clr75;
    if (rst) begin
      m_pt = 0; m_armed = 0; m_p75 = 0; m_lat = 0; m_en = 0;
      m_mask = 3'b111; m_req = 0; m_src = -1; m_vok = 0; m_vec = 0; m_rd = 8'h07;
      return;
    end
    ackv   = ack && m_req;
    rise_t = trap_in && !m_pt;
    m_armed = trap_in && (rise_t || (m_armed && !(ackv && m_src == 0)));
    rise75 = ln_hi_in && !m_p75;
    clr75  = (ackv && m_src == 1) || (mask_wr && mask_wdata[4]);
    m_lat  = (m_lat && !clr75) || rise75;
    if (mask_wr && mask_wdata[3]) m_mask = mask_wdata[2:0];
    if (ackv) m_en = 0; else if (di_stb) m_en = 0; else if (ei_stb) m_en = 1;
    if (m_armed)                                   m_src = 0;
    else if (m_en && m_lat && !m_mask[2])          m_src = 1;
    else if (m_en && ln_mid_in && !m_mask[1])      m_src = 2;
    else if (m_en && ln_lo_in && !m_mask[0])       m_src = 3;
    else if (m_en && gen_req_in)                   m_src = 4;
    else                                           m_src = -1;
    m_req = (m_src >= 0);
    m_vok = (m_src >= 0) && (m_src <= 3);
    m_vec = vec_of(m_src);
    m_rd  = {1'b0, m_lat, ln_mid_in, ln_lo_in, m_en, m_mask};
    m_pt  = trap_in;
    m_p75 = ln_hi_in;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk_val(string tag, int got, int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk(string tag);
    chk_val({tag, " req"}, int'(irq_req), int'(m_req));
    chk_val({tag, " vec_ok"}, int'(irq_vec_ok), int'(m_vok));
    chk_val({tag, " rdata"}, int'(mask_rdata), int'(m_rd));
    if (m_vok) chk_val({tag, " vec"}, int'(irq_vec), int'(m_vec));
  endtask

  task automatic quiet();
    ei_stb = 0; di_stb = 0; mask_wr = 0; ack = 0; mask_wdata = 8'h00;
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    rst = 1; trap_in = 0; ln_hi_in = 0; ln_mid_in = 0; ln_lo_in = 0; gen_req_in = 0;
    quiet();
    seed = $urandom(32'd20110523);
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    cyc();
    chk("R11 reset");
    chk_val("R11 reset rdata", int'(mask_rdata), 'h07);
    chk_val("R11 reset req", int'(irq_req), 0);

    // R5: request with flag clear and line masked
    ln_lo_in = 1; cyc(); chk("R5 disabled");
    // R7: unmask all three lines (08h)
    mask_wr = 1; mask_wdata = 8'h08; cyc(); quiet();
    chk("R7 unmask");
    chk_val("R7 readback", int'(mask_rdata), 'h10);
    chk_val("R5 still off", int'(irq_req), 0);
    ei_stb = 1; cyc(); quiet();
    chk("R5 enabled");
    chk_val("R2 low vector", int'(irq_vec), 'h002C);
    // R1: middle beats low
    ln_mid_in = 1; cyc(); chk("R1 mid over low");
    chk_val("R1 mid vector", int'(irq_vec), 'h0034);
    // R8: pulse on high line is held
    ln_hi_in = 1; cyc(); ln_hi_in = 0; cyc();
    chk("R8 latched pulse");
    chk_val("R8 hi vector", int'(irq_vec), 'h003C);
    // R6: acknowledge clears the flag and the latch
    ack = 1; cyc(); quiet();
    chk("R6 ack");
    chk_val("R6 req dropped", int'(irq_req), 0);
    chk_val("R8 latch cleared", int'(mask_rdata[6]), 0);
    ack = 1; cyc(); quiet(); chk("R6 ack ignored");
    // R3: non-maskable with flag clear
    trap_in = 1; cyc(); chk("R3 trap");
    chk_val("R3 trap vector", int'(irq_vec), 'h0024);
    // R4: no re-recognition while held
    ack = 1; cyc(); quiet(); chk("R4 after ack");
    chk_val("R4 no trap", int'(irq_req), 0);
    cyc(); chk("R4 held high");
    trap_in = 0; cyc(); trap_in = 1; cyc(); chk("R4 rearmed");
    chk_val("R4 rearmed req", int'(irq_req), 1);
    ack = 1; trap_in = 0; cyc(); quiet(); chk("R4 ack");
    // R2: general line has no vector; R9 level withdraw
    ln_mid_in = 0; ln_lo_in = 0; ei_stb = 1; cyc(); quiet();
    gen_req_in = 1; cyc(); chk("R2 general");
    chk_val("R2 general vec_ok", int'(irq_vec_ok), 0);
    chk_val("R2 general req", int'(irq_req), 1);
    gen_req_in = 0; cyc(); chk("R9 withdraw");
    chk_val("R9 req low", int'(irq_req), 0);
    // R7: write without bit 3 keeps masks
    mask_wr = 1; mask_wdata = 8'h07; cyc(); quiet();
    chk("R7 no set-enable");
    chk_val("R7 masks kept", int'(mask_rdata[2:0]), 0);
    // R8: clear by write bit 4
    ln_hi_in = 1; cyc(); ln_hi_in = 0; cyc(); chk("R8 pending");
    mask_wr = 1; mask_wdata = 8'h10; cyc(); quiet();
    chk("R8 write clear");
    chk_val("R8 write clear req", int'(irq_req), 0);
    // R10: readback layout
    ln_mid_in = 1; mask_wr = 1; mask_wdata = 8'h0D; cyc(); quiet();
    chk("R10 readback");
    chk_val("R10 readback value", int'(mask_rdata), 'h2D);
    // R12 and all others: random traffic
    for (int k = 0; k < 4000; k++) begin
      quiet();
      if ($urandom % 16 == 0) trap_in = ~trap_in;
      if ($urandom % 8 == 0)  ln_hi_in = ~ln_hi_in;
      if ($urandom % 8 == 0)  ln_mid_in = ~ln_mid_in;
      if ($urandom % 8 == 0)  ln_lo_in = ~ln_lo_in;
      if ($urandom % 8 == 0)  gen_req_in = ~gen_req_in;
      ei_stb = ($urandom % 5 == 0);
      di_stb = ($urandom % 11 == 0);
      if ($urandom % 12 == 0) begin mask_wr = 1; mask_wdata = 8'($urandom); end
      ack = m_req && ($urandom % 2 == 0);
      cyc();
      chk("R12 R1 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule